// File: doc/BRIEF.md
# Rate-One-Half Convolutional Encoder with Serial Output

This block encodes a bit-serial data stream with a four-state convolutional code at rate one half. Each data bit accepted on the input handshake produces two code bits, which come out one per clock on a single serial line marked by a valid flag. The encoder memory holds the two most recent accepted data bits. The current memory contents are visible on a debug port.

The first code bit is the exclusive OR of the new bit and both remembered bits. The second code bit is the exclusive OR of the new bit and the older remembered bit. The serializer puts the first code bit on the output in the cycle after acceptance and the second code bit in the cycle after that. While the second bit is still held, the input is not ready. An upstream source that offers a bit on every cycle in which the block is ready therefore gets one accepted bit every two cycles and a continuous coded stream.

Top module: `conv_half_rate_enc`

## Requirements
- R1: While reset is high at a clock edge, the next cycle shows dbg_state = 2'b00, out_valid = 0 and in_ready = 1. This also holds when reset arrives while a code pair is only half sent.
- R2: A bit is accepted when in_valid and in_ready are both high at a rising edge. From the next cycle, dbg_state[1] holds the accepted bit and dbg_state[0] holds the previous value of dbg_state[1].
- R3: In the cycle after acceptance, out_valid = 1 and out_bit = in_bit XOR dbg_state[1] XOR dbg_state[0], with the state taken as it was before acceptance.
- R4: In the second cycle after acceptance, out_valid = 1 and out_bit = in_bit XOR dbg_state[0], with the state taken as it was before acceptance.
- R5: out_valid is low in any cycle that neither R3 nor R4 covers.
- R6: in_ready is low exactly in the cycle after an acceptance, while the second code bit is pending, and is high in all other cycles.
- R7: A bit offered while in_ready is low is ignored. The state does not change, and the pending second code bit comes out unchanged.
- R8: Offering a new bit in every ready cycle gives an unbroken stream, with out_valid high on every cycle. The output follows the code table over all eight pairs of state and input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A data bit is offered |
| in_bit | input | 1 | Data bit to encode |
| in_ready | output | 1 | Block can accept a bit at the next edge |
| out_valid | output | 1 | out_bit carries a code bit |
| out_bit | output | 1 | Serial code bit stream |
| dbg_state | output | 2 | Encoder memory: [1] newest bit, [0] older bit |

## Verification
The hardest situations to reach are a bit offered in the busy cycle and a reset that lands between the two halves of a pair. The directed stimulus keeps in_valid high through the busy cycle with the opposite data bit. It then checks that the second code bit and the state are exactly what the first bit alone produces. A separate scenario asserts reset in the cycle right after an acceptance and checks that the pending second bit never appears. The table walk uses an input order that passes through all eight combinations of state and input, with no idle cycle between bits.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;

  // Parity of the bits of a window that a tap mask selects.
  function automatic logic masked_parity(input logic [31:0] window,
                                         input logic [31:0] taps);
    return ^(window & taps);
  endfunction

endpackage

// File: rtl/conv_state_reg.sv
module conv_state_reg #(
  parameter int unsigned MEM_LEN = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic               new_bit,
  output logic [MEM_LEN-1:0] state
);

  // Newest bit in the top position, oldest at bit 0.
  generate
    if (MEM_LEN == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)           state <= '0;
        else if (shift_en) state <= new_bit;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)           state <= '0;
        else if (shift_en) state <= {new_bit, state[MEM_LEN-1:1]};
      end
    end
  endgenerate

endmodule

// File: rtl/conv_code_gen.sv
module conv_code_gen
  import conv_enc_pkg::*;
#(
  parameter int unsigned MEM_LEN = 2,
  parameter int unsigned N_OUT   = 2,
  parameter logic [N_OUT*(MEM_LEN+1)-1:0] GEN_TAPS = 6'b101_111
) (
  input  logic               data_bit,
  input  logic [MEM_LEN-1:0] state,
  output logic [N_OUT-1:0]   code
);

  localparam int unsigned WIN = MEM_LEN + 1;

  logic [WIN-1:0] window;
  assign window = {data_bit, state};

  // Code bit j uses tap slice j; bit 0 goes out first.
  generate
    for (genvar j = 0; j < N_OUT; j++) begin : g_out
      assign code[j] = masked_parity(32'(window), 32'(GEN_TAPS[j*WIN +: WIN]));
    end
  endgenerate

endmodule

// File: rtl/conv_p2s.sv
module conv_p2s #(
  parameter int unsigned N_OUT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [N_OUT-1:0] par_in,
  output logic             ready,
  output logic             ser_valid,
  output logic             ser_bit
);

  localparam int unsigned CNT_W = $clog2(N_OUT + 1);

  logic [N_OUT-1:0] hold;
  logic [CNT_W-1:0] remain;

  assign ready = (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold      <= '0;
      remain    <= '0;
      ser_valid <= 1'b0;
      ser_bit   <= 1'b0;
    end else if (load) begin
      ser_bit   <= par_in[0];
      hold      <= par_in >> 1;
      remain    <= CNT_W'(N_OUT - 1);
      ser_valid <= 1'b1;
    end else if (remain != '0) begin
      ser_bit   <= hold[0];
      hold      <= hold >> 1;
      remain    <= remain - 1'b1;
      ser_valid <= 1'b1;
    end else begin
      ser_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/conv_half_rate_enc.sv
module conv_half_rate_enc #(
  parameter int unsigned MEM_LEN = 2,
  parameter int unsigned N_OUT   = 2,
  parameter logic [N_OUT*(MEM_LEN+1)-1:0] GEN_TAPS = 6'b101_111
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_bit,
  output logic               in_ready,
  output logic               out_valid,
  output logic               out_bit,
  output logic [MEM_LEN-1:0] dbg_state
);

  logic             accept;
  logic [N_OUT-1:0] code;
  logic             p2s_ready;

  assign accept   = in_valid & p2s_ready;
  assign in_ready = p2s_ready;

  conv_state_reg #(.MEM_LEN(MEM_LEN)) u_state (
    .clk      (clk),
    .rst      (rst),
    .shift_en (accept),
    .new_bit  (in_bit),
    .state    (dbg_state)
  );

  conv_code_gen #(.MEM_LEN(MEM_LEN), .N_OUT(N_OUT), .GEN_TAPS(GEN_TAPS)) u_code (
    .data_bit (in_bit),
    .state    (dbg_state),
    .code     (code)
  );

  conv_p2s #(.N_OUT(N_OUT)) u_p2s (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .par_in    (code),
    .ready     (p2s_ready),
    .ser_valid (out_valid),
    .ser_bit   (out_bit)
  );

endmodule

// File: rtl/conv_half_rate_enc_chk.sv
module conv_half_rate_enc_chk #(
  parameter int unsigned MEM_LEN = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_bit,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_bit,
  input logic [MEM_LEN-1:0] dbg_state
);

  logic acc;
  assign acc = in_valid & in_ready;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (dbg_state == '0 && !out_valid && in_ready));

  // R2
  state_shift_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> (dbg_state == {$past(in_bit), $past(dbg_state[MEM_LEN-1])}));

  // R3
  first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> (out_valid && out_bit == $past(in_bit ^ (^dbg_state))));

  // R4
  second_bit_chk: assert property (@(posedge clk) disable iff (rst)
    acc |-> ##2 (out_valid && out_bit == $past(in_bit ^ dbg_state[0], 2)));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !acc) |=> !out_valid);

  // R6
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready);

  // R6
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> !in_ready);

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> $stable(dbg_state));

endmodule

bind conv_half_rate_enc conv_half_rate_enc_chk #(.MEM_LEN(MEM_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_bit    (in_bit),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_bit   (out_bit),
  .dbg_state (dbg_state)
);

// File: tb/conv_half_rate_enc_tb.sv
`timescale 1ns/1ps
module conv_half_rate_enc_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       in_ready;
  logic       out_valid;
  logic       out_bit;
  logic [1:0] dbg_state;

  int n_cmp = 0;
  int n_err = 0;
  logic [1:0] exp_state = 2'b00;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  conv_half_rate_enc u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .dbg_state (dbg_state)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Offer one bit at a negedge; checks both code bits. When poke is set,
  // the inverted bit is offered during the busy cycle.
  task automatic send_bit(input logic b, input logic poke, input string req);
    logic u1, u2;
    logic [1:0] ns;
    u1 = b ^ exp_state[1] ^ exp_state[0];
    u2 = b ^ exp_state[0];
    ns = {b, exp_state[1]};
    in_valid = 1'b1;
    in_bit   = b;
    @(negedge clk);
    chk({req, "/R3"}, "first valid", 8'(out_valid), 8'd1);
    chk({req, "/R3"}, "first bit", 8'(out_bit), 8'(u1));
    chk("R6", "ready busy", 8'(in_ready), 8'd0);
    chk("R2", "state", 8'(dbg_state), 8'(ns));
    if (poke) begin
      in_valid = 1'b1;
      in_bit   = ~b;
    end else begin
      in_valid = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, "/R4"}, "second valid", 8'(out_valid), 8'd1);
    chk({req, "/R4"}, "second bit", 8'(out_bit), 8'(u2));
    chk("R6", "ready back", 8'(in_ready), 8'd1);
    chk(poke ? "R7" : "R2", "state hold", 8'(dbg_state), 8'(ns));
    exp_state = ns;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "state", 8'(dbg_state), 8'd0);
    chk("R1", "out_valid", 8'(out_valid), 8'd0);
    chk("R1", "in_ready", 8'(in_ready), 8'd1);
    exp_state = 2'b00;
  endtask

  task automatic t_table;
    // Covers all eight state/input pairs back to back.
    logic seq [8] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
    foreach (seq[i]) send_bit(seq[i], 1'b0, "R8");
    chk("R8", "end state", 8'(dbg_state), 8'd0);
  endtask

  task automatic t_idle;
    send_bit(1'b1, 1'b0, "R5");
    @(negedge clk);
    chk("R5", "idle valid", 8'(out_valid), 8'd0);
    chk("R5", "idle ready", 8'(in_ready), 8'd1);
    chk("R5", "idle state", 8'(dbg_state), 8'(exp_state));
    @(negedge clk);
    chk("R5", "idle valid 2", 8'(out_valid), 8'd0);
  endtask

  task automatic t_ignore;
    send_bit(1'b0, 1'b1, "R7");
    send_bit(1'b1, 1'b1, "R7");
    send_bit(1'b1, 1'b1, "R7");
    @(negedge clk);
    chk("R7", "no extra output", 8'(out_valid), 8'd0);
    chk("R7", "state kept", 8'(dbg_state), 8'(exp_state));
  endtask

  task automatic t_mid_reset;
    in_valid = 1'b1;
    in_bit   = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6", "busy before reset", 8'(in_ready), 8'd0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "mid reset valid", 8'(out_valid), 8'd0);
    chk("R1", "mid reset state", 8'(dbg_state), 8'd0);
    chk("R1", "mid reset ready", 8'(in_ready), 8'd1);
    exp_state = 2'b00;
    @(negedge clk);
    chk("R1", "no stale bit", 8'(out_valid), 8'd0);
    send_bit(1'b1, 1'b0, "R1");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_table();
    t_idle();
    t_ignore();
    t_mid_reset();
    t_table();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

endmodule